// File: doc/BRIEF.md
# Four-Channel DMA Controller

This block moves data between peripherals and memory without the processor touching each word. Software sets up each of four channels with a start address, a cycle count and a control word that holds a transfer type and an enable bit. A peripheral that wants service raises its request line. The controller combines the requests of all enabled channels into one bus-hold request to the processor.

Once the processor grants the bus, the controller runs one-clock transfer cycles. Each cycle serves the highest-priority requesting channel. In every cycle it drives that channel's current address, the memory and peripheral strobes for the channel's transfer type, and an acknowledge to the peripheral being served. Arbitration is done again at every cycle boundary, so a more urgent channel can step in between two cycles of a long transfer.

When a channel performs its last programmed cycle, the controller pulses that channel's terminal-count line to its peripheral. It then clears the channel's enable bit, so the channel stops taking part in arbitration. The bus request is withdrawn in the cycle after no enabled channel is still requesting.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, every channel register reads zero. `hrq`, `dack`, `tc`, all four strobes and `mem_addr` are low.
- R2: `reg_sel` = {channel[1:0], field[1:0]} selects a register for writing with `reg_we` and for reading on `reg_rdata`. Field 0 is the 16-bit address. Field 1 is the 14-bit count. Field 2 is the control word, with bit 0 = enable and bits 2:1 = transfer type. Field 3 holds no storage: writes to it change nothing and it reads as zero.
- R3: `hrq` rises in the cycle after an enabled channel's `dreq` is sampled high. It stays high while any enabled channel requests. A request from a disabled channel is ignored: no `hrq`, no `dack`, and the channel's address does not change.
- R4: No transfer cycle starts until `hlda` is sampled high. The first `dack` appears in the clock cycle after the edge that sees `hlda` high while `hrq` is asserted.
- R5: Each transfer cycle lasts one clock and serves one channel. Priority is fixed, with channel 0 highest and channel 3 lowest. The winner is chosen again at each cycle boundary, so a higher-priority request that arrives mid-transfer is served in the next cycle.
- R6: During a transfer cycle, `mem_addr` equals the served channel's address register. After the cycle the address has increased by one, wrapping modulo 2^16, and the count has decreased by one, wrapping modulo 2^14.
- R7: A count of N gives exactly N+1 transfer cycles. `tc` of the channel pulses high together with `dack` in the last cycle only, and after that cycle the channel's enable bit reads 0.
- R8: Transfer type 1 (memory write) asserts `mem_wr` and `io_rd` during the cycle. Type 2 (memory read) asserts `mem_rd` and `io_wr`. Types 0 (verify) and 3 (reserved) assert no strobe.
- R9: `dack` is one-hot during a transfer cycle, marking the served channel, and all zero otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Channel and field select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Selected register contents |
| dreq | input | 4 | Peripheral service requests, one per channel |
| hlda | input | 1 | Bus grant from the processor |
| hrq | output | 1 | Combined bus-hold request |
| dack | output | 4 | Per-channel acknowledge for the current cycle |
| tc | output | 4 | Per-channel terminal-count pulse |
| mem_addr | output | 16 | Memory address of the current cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |

## Verification
The hardest situation to reach from the ports is a higher-priority request arriving in the middle of a lower channel's run. The request has to land exactly between two transfer cycles, and the lower channel must then resume with its address and count intact. The stimulus starts channel 3 on a six-cycle run and watches `dack` at each falling edge. It raises channel 0's request immediately after the second channel-3 cycle is seen, then records the order in which the channels are served and compares it with the expected interleaving. Address wrap and the single-cycle count of zero are reached through entries in the vector table.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

   // register field selector, low two bits of the select bus
   typedef enum logic [1:0] {
      FLD_ADDR  = 2'd0,
      FLD_COUNT = 2'd1,
      FLD_CTRL  = 2'd2,
      FLD_NONE  = 2'd3
   } reg_field_t;

   // cycle type held in control bits 2:1
   typedef enum logic [1:0] {
      XT_VERIFY = 2'd0,
      XT_MEMWR  = 2'd1,
      XT_MEMRD  = 2'd2,
      XT_RSVD   = 2'd3
   } xfer_type_t;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_REQ  = 2'd1,
      SQ_XFER = 2'd2
   } seq_state_t;

endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
   import dma4_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_field_t        wr_fld,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              step,
   output logic [ADDR_W-1:0] addr_q,
   output logic [CNT_W-1:0]  cnt_q,
   output xfer_type_t        type_q,
   output logic              en_q,
   output logic              last
);

   generate
      if (CNT_W < 1 || CNT_W > ADDR_W) begin : g_bad_cnt
         $error("dma4_chan: CNT_W must lie in 1..ADDR_W");
      end
   endgenerate

   assign last = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
         type_q <= XT_VERIFY;
         en_q   <= 1'b0;
      end else begin
         if (step) begin
            addr_q <= addr_q + 1'b1;
            cnt_q  <= cnt_q - 1'b1;
            if (last) en_q <= 1'b0;
         end
         // a software write wins over the cycle update
         if (wr_en) begin
            case (wr_fld)
               FLD_ADDR:  addr_q <= wr_data;
               FLD_COUNT: cnt_q  <= wr_data[CNT_W-1:0];
               FLD_CTRL: begin
                  en_q   <= wr_data[0];
                  type_q <= xfer_type_t'(wr_data[2:1]);
               end
               default: ;
            endcase
         end
      end
   end

   // R6
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !(wr_en && wr_fld == FLD_ADDR)) |=> addr_q == $past(addr_q) + 1'b1);

   // R6
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !wr_en) |=> $stable(cnt_q) && $stable(addr_q));

   // R7
   en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last && !(wr_en && wr_fld == FLD_CTRL)) |=> !en_q);

endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
   parameter int NUM_CH = 4,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [NUM_CH-1:0] req,
   output logic [NUM_CH-1:0] grant,
   output logic [CH_W-1:0]   win_idx,
   output logic              any
);

   logic [NUM_CH:0] blocked;
   assign blocked[0] = 1'b0;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_prio
         assign grant[i]     = req[i] & ~blocked[i];
         assign blocked[i+1] = blocked[i] | req[i];
      end
   endgenerate

   assign any = blocked[NUM_CH];

   always_comb begin
      win_idx = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (grant[i]) win_idx = CH_W'(i);
      end
   end

endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
   import dma4_pkg::*;
#(
   parameter int CH_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            any_elig,
   input  logic            hlda,
   input  logic [CH_W-1:0] win_idx,
   output logic            busy,
   output logic            xfer,
   output logic [CH_W-1:0] cur_idx
);

   seq_state_t state_q;

   assign busy = (state_q != SQ_IDLE);
   assign xfer = (state_q == SQ_XFER);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cur_idx <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (any_elig) state_q <= SQ_REQ;
            end
            SQ_REQ: begin
               if (!any_elig) begin
                  state_q <= SQ_IDLE;
               end else if (hlda) begin
                  state_q <= SQ_XFER;
                  cur_idx <= win_idx;
               end
            end
            SQ_XFER: begin
               if (!any_elig) begin
                  state_q <= SQ_IDLE;
               end else if (hlda) begin
                  cur_idx <= win_idx;
               end else begin
                  state_q <= SQ_REQ;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   // R4
   xfer_needs_hlda_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |-> $past(hlda));

   // R3
   req_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !hlda && any_elig) |=> (busy && !xfer));

endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
   import dma4_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 14,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int SEL_W = CH_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic [NUM_CH-1:0] dreq,
   input  logic              hlda,
   output logic              hrq,
   output logic [NUM_CH-1:0] dack,
   output logic [NUM_CH-1:0] tc,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              io_rd,
   output logic              io_wr
);

   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("dma4_ctrl: NUM_CH must be at least 2");
      end
      if (ADDR_W < 3) begin : g_bad_aw
         $error("dma4_ctrl: ADDR_W must hold the control word");
      end
   endgenerate

   logic [CH_W-1:0]   sel_ch;
   reg_field_t        sel_fld;
   assign sel_ch  = reg_sel[SEL_W-1:2];
   assign sel_fld = reg_field_t'(reg_sel[1:0]);

   logic [ADDR_W-1:0] addr_a [NUM_CH];
   logic [CNT_W-1:0]  cnt_a  [NUM_CH];
   xfer_type_t        type_a [NUM_CH];
   logic [NUM_CH-1:0] en_vec;
   logic [NUM_CH-1:0] last_vec;
   logic [NUM_CH-1:0] step_vec;

   logic              xfer;
   logic [CH_W-1:0]   cur_idx;
   logic [NUM_CH-1:0] cur_oh;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         assign step_vec[i] = cur_oh[i];
         dma4_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_we && sel_ch == CH_W'(i)),
            .wr_fld  (sel_fld),
            .wr_data (reg_wdata),
            .step    (step_vec[i]),
            .addr_q  (addr_a[i]),
            .cnt_q   (cnt_a[i]),
            .type_q  (type_a[i]),
            .en_q    (en_vec[i]),
            .last    (last_vec[i])
         );
      end
   endgenerate

   always_comb begin
      cur_oh = '0;
      if (xfer) cur_oh[cur_idx] = 1'b1;
   end

   // a channel in its final cycle drops out of the next arbitration
   logic [NUM_CH-1:0] elig;
   logic [NUM_CH-1:0] grant;
   logic [CH_W-1:0]   win_idx;
   logic              any_elig;

   assign elig = dreq & en_vec & ~(cur_oh & last_vec);

   dma4_arb #(.NUM_CH(NUM_CH)) u_arb (
      .req     (elig),
      .grant   (grant),
      .win_idx (win_idx),
      .any     (any_elig)
   );

   dma4_seq #(.CH_W(CH_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .any_elig (any_elig),
      .hlda     (hlda),
      .win_idx  (win_idx),
      .busy     (hrq),
      .xfer     (xfer),
      .cur_idx  (cur_idx)
   );

   xfer_type_t cur_type;
   assign cur_type = type_a[cur_idx];

   assign dack     = cur_oh;
   assign tc       = cur_oh & last_vec;
   assign mem_addr = xfer ? addr_a[cur_idx] : '0;
   assign mem_wr   = xfer && (cur_type == XT_MEMWR);
   assign io_rd    = xfer && (cur_type == XT_MEMWR);
   assign mem_rd   = xfer && (cur_type == XT_MEMRD);
   assign io_wr    = xfer && (cur_type == XT_MEMRD);

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (sel_ch == CH_W'(i)) begin
            case (sel_fld)
               FLD_ADDR:  reg_rdata = addr_a[i];
               FLD_COUNT: reg_rdata = ADDR_W'(cnt_a[i]);
               FLD_CTRL:  reg_rdata = ADDR_W'({type_a[i], en_vec[i]});
               default:   reg_rdata = '0;
            endcase
         end
      end
   end

   // R9
   dack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dack) && (xfer == (dack != '0)));

   // R7
   tc_with_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc & ~dack) == '0);

   // R8
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((mem_rd || io_wr) && (mem_wr || io_rd)));

   // R3
   hrq_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hrq && (dreq & en_vec) != '0) |=> hrq);

   // R5
   grant_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_elig |-> ($onehot(grant) && (grant & elig) == grant
                    && ((grant - NUM_CH'(1)) & elig) == '0));

endmodule

// File: tb/tb_dma4_ctrl.sv
module tb_dma4_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_sel = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [3:0]  dreq = '0;
   logic        hlda = 1'b0;
   logic        hrq;
   logic [3:0]  dack;
   logic [3:0]  tc;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr, io_rd, io_wr;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   dma4_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
      .hlda(hlda), .hrq(hrq), .dack(dack), .tc(tc), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr)
   );

   // {channel, type, start address, count}
   localparam int NV = 5;
   localparam logic [33:0] VEC [NV] = '{
      {2'd0, 2'd1, 16'h1000, 14'd4},
      {2'd1, 2'd2, 16'h2F00, 14'd7},
      {2'd2, 2'd0, 16'hFFFE, 14'd3},
      {2'd3, 2'd3, 16'h0040, 14'd0},
      {2'd2, 2'd1, 16'h8000, 14'd20}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int ch, input int fld, input int data);
      @(negedge clk);
      reg_we = 1'b1;
      reg_sel = 4'((ch << 2) | fld);
      reg_wdata = 16'(data);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int ch, input int fld, output int data);
      reg_sel = 4'((ch << 2) | fld);
      #1;
      data = int'(reg_rdata);
   endtask

   function automatic int idx_of(input logic [3:0] v);
      for (int i = 0; i < 4; i++) if (v[i]) return i;
      return -1;
   endfunction

   task automatic run_vec(input int ch, input int ty, input int start, input int cnt);
      int n = 0;
      int tcn = 0;
      int tc_at = -1;
      int bad_addr = 0;
      int bad_strb = 0;
      int v;
      wr(ch, 0, start);
      wr(ch, 1, cnt);
      wr(ch, 2, (ty << 1) | 1);
      dreq[ch] = 1'b1;
      for (int c = 0; c < 200; c++) begin
         @(negedge clk);
         if (dack != 4'd0) begin
            if (dack != 4'(1 << ch)) bad_strb++;
            if (int'(mem_addr) != ((start + n) & 16'hFFFF)) bad_addr++;
            if (ty == 1 && !(mem_wr && io_rd && !mem_rd && !io_wr)) bad_strb++;
            if (ty == 2 && !(mem_rd && io_wr && !mem_wr && !io_rd)) bad_strb++;
            if ((ty == 0 || ty == 3) && (mem_rd || mem_wr || io_rd || io_wr)) bad_strb++;
            n++;
            if (tc[ch]) begin tcn++; tc_at = n; end
         end
         if (n > 0 && !hrq) break;
      end
      dreq[ch] = 1'b0;
      chk(n == cnt + 1, "R7 cycle count", n, cnt + 1);
      chk(tcn == 1 && tc_at == cnt + 1, "R7 tc on last cycle", tc_at, cnt + 1);
      chk(bad_addr == 0, "R6 address sequence", bad_addr, 0);
      chk(bad_strb == 0, "R8 strobes for type", bad_strb, 0);
      rd(ch, 2, v);
      chk((v & 1) == 0, "R7 enable cleared", v, ty << 1);
      rd(ch, 0, v);
      chk(v == ((start + cnt + 1) & 16'hFFFF), "R6 final address", v, (start + cnt + 1) & 16'hFFFF);
      rd(ch, 1, v);
      chk(v == 16'h3FFF, "R6 count wrapped", v, 16'h3FFF);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      int v;
      int seq [16];
      int sn;
      int n3;
      int errs;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(!hrq && dack == 0 && tc == 0, "R1 handshake idle", {hrq, dack, tc}, 0);
      chk(!mem_rd && !mem_wr && !io_rd && !io_wr && mem_addr == 0, "R1 bus idle",
          {mem_rd, mem_wr, io_rd, io_wr}, 0);
      errs = 0;
      for (int c = 0; c < 4; c++)
         for (int f = 0; f < 3; f++) begin
            rd(c, f, v);
            if (v != 0) errs++;
         end
      chk(errs == 0, "R1 registers zero", errs, 0);

      // R2 register access
      wr(1, 0, 16'hABCD);
      rd(1, 0, v);
      chk(v == 16'hABCD, "R2 address readback", v, 16'hABCD);
      wr(1, 1, 16'hFFFF);
      rd(1, 1, v);
      chk(v == 16'h3FFF, "R2 count is 14 bits", v, 16'h3FFF);
      wr(1, 3, 16'h1234);
      rd(1, 3, v);
      chk(v == 0, "R2 field 3 reads zero", v, 0);
      rd(1, 0, v);
      chk(v == 16'hABCD, "R2 field 3 write ignored", v, 16'hABCD);

      // vector table, hlda granted throughout
      hlda = 1'b1;
      for (int i = 0; i < NV; i++)
         run_vec(int'(VEC[i][33:32]), int'(VEC[i][31:30]), int'(VEC[i][29:14]), int'(VEC[i][13:0]));

      // R3 disabled channel ignored
      wr(2, 0, 16'h0500);
      wr(2, 2, 0);
      dreq[2] = 1'b1;
      errs = 0;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         if (hrq || dack != 0) errs++;
      end
      dreq[2] = 1'b0;
      chk(errs == 0, "R3 disabled request ignored", errs, 0);
      rd(2, 0, v);
      chk(v == 16'h0500, "R3 disabled address unchanged", v, 16'h0500);

      // R4 wait for hlda
      hlda = 1'b0;
      wr(0, 0, 16'h0100);
      wr(0, 1, 1);
      wr(0, 2, 1);
      dreq[0] = 1'b1;
      errs = 0;
      repeat (5) begin
         @(negedge clk);
         if (dack != 0) errs++;
      end
      chk(hrq && errs == 0, "R4 hrq without dack", {hrq, 4'(errs)}, 16);
      @(negedge clk);
      hlda = 1'b1;
      @(negedge clk);
      chk(dack == 4'b0001 && mem_addr == 16'h0100, "R4 dack after hlda", dack, 1);
      @(negedge clk);
      chk(dack == 4'b0001 && tc == 4'b0001, "R7 second cycle is last", tc, 1);
      @(negedge clk);
      chk(!hrq && dack == 0, "R3 hrq released", hrq, 0);
      dreq[0] = 1'b0;

      // R5 simultaneous requests
      wr(1, 1, 1); wr(1, 2, 1);
      wr(2, 1, 1); wr(2, 2, 1);
      dreq = 4'b0110;
      sn = 0;
      for (int c = 0; c < 40 && sn < 16; c++) begin
         @(negedge clk);
         if (dack != 0) begin seq[sn] = idx_of(dack); sn++; end
         if (sn > 0 && !hrq) break;
      end
      dreq = 0;
      chk(sn == 4 && seq[0] == 1 && seq[1] == 1 && seq[2] == 2 && seq[3] == 2,
          "R5 fixed priority order", sn == 4 ? seq[0]*1000 + seq[1]*100 + seq[2]*10 + seq[3] : sn, 1122);

      // R5 higher channel steps in between cycles
      wr(3, 1, 5); wr(3, 2, 1);
      wr(0, 1, 0); wr(0, 2, 1);
      dreq = 4'b1000;
      sn = 0;
      n3 = 0;
      for (int c = 0; c < 40 && sn < 16; c++) begin
         @(negedge clk);
         if (dack != 0) begin
            seq[sn] = idx_of(dack);
            sn++;
            if (dack[3]) begin
               n3++;
               if (n3 == 2) dreq[0] = 1'b1;
            end
         end
         if (sn > 0 && !hrq) break;
      end
      dreq = 0;
      errs = 0;
      if (sn != 7) errs++;
      else begin
         for (int k = 0; k < 7; k++) if (seq[k] != ((k == 2) ? 0 : 3)) errs++;
      end
      chk(errs == 0, "R5 preemption at boundary", sn, 7);
      chk(n3 == 6, "R9 lower channel resumes", n3, 6);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule